// File: doc/BRIEF.md
# Indirect Register Select Window

This block provides a select register and an alias register decoder. Together they let two control-register addresses reach a larger space of indirectly numbered registers. Software writes an index into the select register. Accesses to the primary alias then read or write the backing register that the index names.

The block holds two backing regions:
- a sixteen-entry major-interrupt priority array at indices 0x30 to 0x3F;
- a small set of external-interrupt file stub registers starting at 0x70, present only when a message-signalled interrupt file is configured.

Any alias access that the configuration does not support completes with an illegal-instruction flag. Such an access changes no state.

The select register is WARL. It stores only the implemented low index bits and one custom-use bit. That bit always appears at the top bit of the current XLEN, so it moves when the XLEN mode changes and keeps its value.

Each request is classified by a small state machine. The state reached decides the registered response in the following cycle. The states are:
- `ST_IDLE`: no request.
- `ST_SEL`: select register access.
- `ST_ALIAS`: legal alias access.
- `ST_TRAP`: illegal alias access.

Every state moves to any of the four on each clock:
- to `ST_IDLE` when no request is present;
- to `ST_SEL` for a select request;
- to `ST_ALIAS` for an alias request whose index decodes to a backing register;
- to `ST_TRAP` for every other request.

Top module: `isel_window`

## Requirements
- R1: After reset, `sel_index` is zero, `rsp_valid` is low, and every backing register reads as zero.
- R2: The select register keeps index bits 5:0 (machine level without an interrupt file), 7:0 (machine level with one) or 8:0 (supervisor level). All bits between the implemented ones and the custom bit read as zero.
- R3: A select write stores bit 63 of `req_wdata` as the custom bit when `xlen64` is 1, and bit 31 when `xlen64` is 0. The custom bit reads back at bit 63 or bit 31 respectively.
- R4: When `xlen64` changes and the select register is not written, the custom bit moves to the new top position with its value kept, and the low index is unchanged.
- R5: Target code 0 accesses the select register and code 1 the primary alias. A primary alias access with an index in 0x30..0x3F is legal and reaches priority entry index-0x30.
- R6: With an interrupt file, indices 0x70..0xFF are legal through the primary alias. Entries 0x70..0x77 store data; the rest read zero and ignore writes. Without an interrupt file, the whole range is illegal.
- R7: Target codes 2 to 6 (secondary aliases) and the unused code 7 are illegal for every select value.
- R8: A primary alias access is illegal when the custom bit is set, or when the index lies outside 0x30..0x3F and outside the interrupt-file range.
- R9: An illegal access returns zero read data and alters no select or backing state.
- R10: Every request gets exactly one response (`rsp_valid` high) in the cycle after it, carrying the value held before the request's write. A cycle without a request yields no response.
- R11: When `xlen64` is 0, alias reads return the low 32 bits zero-extended, and alias writes change only the low 32 bits of the backing register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlen64 | input | 1 | Current XLEN mode: 1 = 64-bit, 0 = 32-bit |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | Request writes `req_wdata` |
| req_target | input | 3 | 0 select, 1 primary alias, 2..6 secondary alias, 7 unused |
| req_wdata | input | DATA_W | Write data |
| sel_index | output | DATA_W | Select register as seen at the current XLEN |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_illegal | output | 1 | Previous request raised an illegal-instruction exception |
| rsp_rdata | output | DATA_W | Read data of the previous request |

## Verification
Two instances run side by side on the same stimulus:
- a machine-level instance with an interrupt file;
- a supervisor-level instance without one.

Every select value from 0 to 0x1FF is written and then probed through the primary alias. This sweep separates the two WARL widths, the aliasing of high index bits, and the legality of the priority range, the interrupt-file range and the reserved gaps.

Further patterns cover the remaining behaviour:
- Custom-bit writes in both XLEN modes, followed by mode flips, show whether the bit follows the current top position.
- All secondary target codes are tried on legal indices.
- Paired wide and narrow writes to one priority entry tell a full-width update apart from a low-half update.

// File: rtl/isel_pkg.sv
package isel_pkg;

    typedef enum logic [2:0] {
        TGT_SELECT   = 3'd0,
        TGT_ALIAS1   = 3'd1,
        TGT_ALIAS2   = 3'd2,
        TGT_ALIAS3   = 3'd3,
        TGT_ALIAS4   = 3'd4,
        TGT_ALIAS5   = 3'd5,
        TGT_ALIAS6   = 3'd6,
        TGT_RESERVED = 3'd7
    } isel_target_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEL   = 2'd1,
        ST_ALIAS = 2'd2,
        ST_TRAP  = 2'd3
    } isel_state_e;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_PRIO = 2'd1,
        RGN_EXT  = 2'd2
    } isel_region_e;

    localparam int unsigned PRIO_FIRST = 32'h30;
    localparam int unsigned PRIO_LAST  = 32'h3F;
    localparam int unsigned EXT_FIRST  = 32'h70;
    localparam int unsigned EXT_LAST   = 32'hFF;

    // Number of index bits the select register keeps for a configuration.
    function automatic int sel_impl_bits(input bit supervisor, input bit has_file);
        if (supervisor)
            return 9;
        else if (has_file)
            return 8;
        else
            return 6;
    endfunction

endpackage

// File: rtl/isel_select_reg.sv
module isel_select_reg #(
    parameter int DATA_W    = 64,
    parameter int IMPL_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xlen64,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wdata,
    output logic [IMPL_BITS-1:0] sel_low,
    output logic                 sel_custom,
    output logic [DATA_W-1:0]    sel_view
);
    localparam int NARROW_W = DATA_W / 2;

    logic custom_in;

    // The custom bit is taken from the top of the current XLEN.
    always_comb begin
        custom_in = xlen64 ? wdata[DATA_W-1] : wdata[NARROW_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_low    <= '0;
            sel_custom <= 1'b0;
        end else if (wr_en) begin
            sel_low    <= wdata[IMPL_BITS-1:0];
            sel_custom <= custom_in;
        end
    end

    // Stored custom bit is placed at whichever top bit is current.
    always_comb begin
        sel_view                  = '0;
        sel_view[IMPL_BITS-1:0]   = sel_low;
        if (xlen64)
            sel_view[DATA_W-1]    = sel_custom;
        else
            sel_view[NARROW_W-1]  = sel_custom;
    end

endmodule

// File: rtl/isel_decode.sv
module isel_decode
    import isel_pkg::*;
#(
    parameter int IMPL_BITS = 8,
    parameter bit HAS_FILE  = 1'b1,
    parameter int SLOT_W    = 8
) (
    input  isel_target_e         target,
    input  logic [IMPL_BITS-1:0] sel_low,
    input  logic                 sel_custom,
    output isel_region_e         region,
    output logic [SLOT_W-1:0]    slot,
    output logic                 alias_legal
);
    localparam int IDX_W = 16;

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx    = IDX_W'(sel_low);
        region = RGN_NONE;
        slot   = '0;
        if (!sel_custom) begin
            if (idx >= IDX_W'(PRIO_FIRST) && idx <= IDX_W'(PRIO_LAST)) begin
                region = RGN_PRIO;
                slot   = SLOT_W'(idx - IDX_W'(PRIO_FIRST));
            end else if (HAS_FILE && idx >= IDX_W'(EXT_FIRST) && idx <= IDX_W'(EXT_LAST)) begin
                region = RGN_EXT;
                slot   = SLOT_W'(idx - IDX_W'(EXT_FIRST));
            end
        end
        // Only the primary alias reaches backing registers.
        alias_legal = (target == TGT_ALIAS1) && (region != RGN_NONE);
    end

endmodule

// File: rtl/isel_backing.sv
module isel_backing
    import isel_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int PRIO_N   = 16,
    parameter int EXT_N    = 8,
    parameter bit HAS_FILE = 1'b1,
    parameter int SLOT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlen64,
    input  logic              wr_en,
    input  isel_region_e      region,
    input  logic [SLOT_W-1:0] slot,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int NARROW_W   = DATA_W / 2;
    localparam int PRIO_IDX_W = $clog2(PRIO_N);
    localparam int EXT_IDX_W  = $clog2(EXT_N);

    logic [DATA_W-1:0] prio_view [PRIO_N];
    logic [DATA_W-1:0] ext_view  [EXT_N];

    for (genvar g = 0; g < PRIO_N; g++) begin : g_prio
        logic [DATA_W-1:0] q;
        logic              hit;
        assign hit = wr_en && (region == RGN_PRIO) && (slot == SLOT_W'(g));
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (hit)
                q <= xlen64 ? wdata : {q[DATA_W-1:NARROW_W], wdata[NARROW_W-1:0]};
        end
        assign prio_view[g] = q;
    end

    if (HAS_FILE) begin : g_file
        for (genvar e = 0; e < EXT_N; e++) begin : g_ext
            logic [DATA_W-1:0] q;
            logic              hit;
            assign hit = wr_en && (region == RGN_EXT) && (slot == SLOT_W'(e));
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (hit)
                    q <= xlen64 ? wdata : {q[DATA_W-1:NARROW_W], wdata[NARROW_W-1:0]};
            end
            assign ext_view[e] = q;
        end
    end else begin : g_no_file
        for (genvar e = 0; e < EXT_N; e++) begin : g_zero
            assign ext_view[e] = '0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (region)
            RGN_PRIO: if (int'(slot) < PRIO_N) rdata = prio_view[slot[PRIO_IDX_W-1:0]];
            RGN_EXT:  if (int'(slot) < EXT_N)  rdata = ext_view[slot[EXT_IDX_W-1:0]];
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/isel_window.sv
module isel_window
    import isel_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter bit HAS_FILE   = 1'b1,
    parameter bit SUPERVISOR = 1'b0,
    parameter int EXT_N      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlen64,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_target,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] sel_index,
    output logic              rsp_valid,
    output logic              rsp_illegal,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int IMPL_BITS = sel_impl_bits(SUPERVISOR, HAS_FILE);
    localparam int NARROW_W  = DATA_W / 2;
    localparam int SLOT_W    = 8;
    localparam int PRIO_N    = int'(PRIO_LAST - PRIO_FIRST + 1);

    isel_target_e         tgt;
    logic                 sel_wr;
    logic [IMPL_BITS-1:0] sel_low;
    logic                 sel_custom;
    logic [DATA_W-1:0]    sel_view;
    isel_region_e         region;
    logic [SLOT_W-1:0]    slot;
    logic                 alias_legal;
    logic                 back_wr;
    logic [DATA_W-1:0]    back_rdata;
    isel_state_e          state_d, state_q;
    logic [DATA_W-1:0]    rdata_d, rdata_q;

    assign tgt     = isel_target_e'(req_target);
    assign sel_wr  = req_valid && req_write && (tgt == TGT_SELECT);
    assign back_wr = req_valid && req_write && alias_legal;

    isel_select_reg #(
        .DATA_W    (DATA_W),
        .IMPL_BITS (IMPL_BITS)
    ) u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .xlen64     (xlen64),
        .wr_en      (sel_wr),
        .wdata      (req_wdata),
        .sel_low    (sel_low),
        .sel_custom (sel_custom),
        .sel_view   (sel_view)
    );

    isel_decode #(
        .IMPL_BITS (IMPL_BITS),
        .HAS_FILE  (HAS_FILE),
        .SLOT_W    (SLOT_W)
    ) u_decode (
        .target      (tgt),
        .sel_low     (sel_low),
        .sel_custom  (sel_custom),
        .region      (region),
        .slot        (slot),
        .alias_legal (alias_legal)
    );

    isel_backing #(
        .DATA_W   (DATA_W),
        .PRIO_N   (PRIO_N),
        .EXT_N    (EXT_N),
        .HAS_FILE (HAS_FILE),
        .SLOT_W   (SLOT_W)
    ) u_backing (
        .clk    (clk),
        .rst_n  (rst_n),
        .xlen64 (xlen64),
        .wr_en  (back_wr),
        .region (region),
        .slot   (slot),
        .wdata  (req_wdata),
        .rdata  (back_rdata)
    );

    // Next state: classify the request of this cycle.
    always_comb begin
        if (!req_valid)
            state_d = ST_IDLE;
        else if (tgt == TGT_SELECT)
            state_d = ST_SEL;
        else if (alias_legal)
            state_d = ST_ALIAS;
        else
            state_d = ST_TRAP;

        unique case (state_d)
            ST_SEL:   rdata_d = sel_view;
            ST_ALIAS: rdata_d = xlen64 ? back_rdata
                                       : {{NARROW_W{1'b0}}, back_rdata[NARROW_W-1:0]};
            default:  rdata_d = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= rdata_d;
        end
    end

    // Outputs from the current state.
    always_comb begin
        sel_index = sel_view;
        rsp_rdata = rdata_q;
        unique case (state_q)
            ST_IDLE:  begin rsp_valid = 1'b0; rsp_illegal = 1'b0; end
            ST_SEL:   begin rsp_valid = 1'b1; rsp_illegal = 1'b0; end
            ST_ALIAS: begin rsp_valid = 1'b1; rsp_illegal = 1'b0; end
            ST_TRAP:  begin rsp_valid = 1'b1; rsp_illegal = 1'b1; end
            default:  begin rsp_valid = 1'b0; rsp_illegal = 1'b0; end
        endcase
    end

endmodule

// File: rtl/isel_window_checks.sv
module isel_window_checks #(
    parameter int DATA_W    = 64,
    parameter int IMPL_BITS = 8,
    parameter bit HAS_FILE  = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 xlen64,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [2:0]           req_target,
    input logic [IMPL_BITS-1:0] req_wdata_low,
    input logic [DATA_W-1:0]    sel_index,
    input logic                 rsp_valid,
    input logic                 rsp_illegal,
    input logic [DATA_W-1:0]    rsp_rdata
);
    localparam int NARROW_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LOW_MASK    = (DATA_W'(1) << IMPL_BITS) - DATA_W'(1);
    localparam logic [DATA_W-1:0] WIDE_GAP    = ~LOW_MASK & ~(DATA_W'(1) << (DATA_W - 1));
    localparam logic [DATA_W-1:0] NARROW_GAP  = ~LOW_MASK & ~(DATA_W'(1) << (NARROW_W - 1));

    logic sel_write;
    assign sel_write = req_valid && req_write && (req_target == 3'd0);

    p_sel_low_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_write |=> sel_index[IMPL_BITS-1:0] == $past(req_wdata_low));

    p_gap_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xlen64 ? (sel_index & WIDE_GAP) : (sel_index & NARROW_GAP)) == '0);

    p_custom_moves_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_write && xlen64) ##1 !xlen64 |-> sel_index[NARROW_W-1] == $past(sel_index[DATA_W-1]));

    p_secondary_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_target >= 3'd2) |=> (rsp_valid && rsp_illegal));

    p_custom_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_target == 3'd1 &&
         (xlen64 ? sel_index[DATA_W-1] : sel_index[NARROW_W-1])) |=> rsp_illegal);

    p_trap_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> rsp_rdata == '0);

    p_response_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_narrow_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xlen64) |=> rsp_rdata[DATA_W-1:NARROW_W] == '0);

    if (!HAS_FILE) begin : g_no_file
        p_ext_without_file_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_target == 3'd1 &&
             sel_index[15:0] >= 16'h0070 && sel_index[15:0] <= 16'h00FF) |=> rsp_illegal);
    end

endmodule

bind isel_window isel_window_checks #(
    .DATA_W    (DATA_W),
    .IMPL_BITS (IMPL_BITS),
    .HAS_FILE  (HAS_FILE)
) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .xlen64        (xlen64),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_target    (req_target),
    .req_wdata_low (req_wdata[IMPL_BITS-1:0]),
    .sel_index     (sel_index),
    .rsp_valid     (rsp_valid),
    .rsp_illegal   (rsp_illegal),
    .rsp_rdata     (rsp_rdata)
);

// File: tb/isel_window_test.sv
`timescale 1ns/1ps
module isel_window_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlen64 = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_target = 3'd0;
    logic [63:0] req_wdata = '0;

    logic [63:0] m_sel, m_rd, s_sel, s_rd;
    logic        m_vld, m_ill, s_vld, s_ill;
    logic [63:0] m_rd_c, s_rd_c;
    logic        m_vld_c, m_ill_c, s_vld_c, s_ill_c;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // Machine level with an interrupt file: 8 index bits.
    isel_window #(.DATA_W(64), .HAS_FILE(1'b1), .SUPERVISOR(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .xlen64(xlen64), .req_valid(req_valid),
        .req_write(req_write), .req_target(req_target), .req_wdata(req_wdata),
        .sel_index(m_sel), .rsp_valid(m_vld), .rsp_illegal(m_ill), .rsp_rdata(m_rd));

    // Supervisor level without an interrupt file: 9 index bits.
    isel_window #(.DATA_W(64), .HAS_FILE(1'b0), .SUPERVISOR(1'b1)) uut_nf (
        .clk(clk), .rst_n(rst_n), .xlen64(xlen64), .req_valid(req_valid),
        .req_write(req_write), .req_target(req_target), .req_wdata(req_wdata),
        .sel_index(s_sel), .rsp_valid(s_vld), .rsp_illegal(s_ill), .rsp_rdata(s_rd));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [2:0] tgt, input logic [63:0] wd);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_target = tgt;
        req_wdata  = wd;
        @(posedge clk);
        @(negedge clk);
        m_vld_c = m_vld; m_ill_c = m_ill; m_rd_c = m_rd;
        s_vld_c = s_vld; s_ill_c = s_ill; s_rd_c = s_rd;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic set_xlen(input bit wide);
        @(negedge clk);
        xlen64 = wide;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit exp_illegal(input int v, input bit has_file);
        return !((v >= 'h30 && v <= 'h3F) || (has_file && v >= 'h70 && v <= 'hFF));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R10 watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 sel", m_sel, 64'h0);
        chk("R1 valid", 64'(m_vld), 64'h0);
        chk("R1 sel_s", s_sel, 64'h0);

        // R2/R5/R6/R8 sweep of every select value up to 0x1FF
        for (int v = 0; v < 512; v++) begin
            access(1'b1, 3'd0, 64'(v));
            chk("R2 width m", m_sel, 64'(v & 'hFF));
            chk("R2 width s", s_sel, 64'(v & 'h1FF));
            access(1'b0, 3'd1, 64'h0);
            chk("R5/R6/R8 legality m", 64'(m_ill_c), 64'(exp_illegal(v & 'hFF, 1'b1)));
            chk("R5/R6/R8 legality s", 64'(s_ill_c), 64'(exp_illegal(v, 1'b0)));
            chk("R1/R9 data m", m_rd_c, 64'h0);
            chk("R1/R9 data s", s_rd_c, 64'h0);
        end

        // R10 no response after an idle cycle
        @(negedge clk);
        chk("R10 idle", 64'(m_vld), 64'h0);

        // R3/R4 custom bit in wide mode, then mode flips
        access(1'b1, 3'd0, 64'h8000_0000_0000_0035);
        chk("R10 valid", 64'(m_vld_c), 64'h1);
        chk("R3 wide m", m_sel, 64'h8000_0000_0000_0035);
        chk("R3 wide s", s_sel, 64'h8000_0000_0000_0035);
        access(1'b0, 3'd1, 64'h0);
        chk("R8 custom m", 64'(m_ill_c), 64'h1);
        chk("R8 custom s", 64'(s_ill_c), 64'h1);
        set_xlen(1'b0);
        chk("R4 narrow m", m_sel, 64'h0000_0000_8000_0035);
        set_xlen(1'b1);
        chk("R4 wide again m", m_sel, 64'h8000_0000_0000_0035);

        // R3 narrow-mode writes take the custom bit from bit 31
        set_xlen(1'b0);
        access(1'b1, 3'd0, 64'h8000_0000_0000_01F3);
        chk("R10 pre-write select read", m_rd_c, 64'h0000_0000_8000_0035);
        chk("R3 narrow bit63 ignored m", m_sel, 64'h0000_0000_0000_00F3);
        chk("R3 narrow bit63 ignored s", s_sel, 64'h0000_0000_0000_01F3);
        access(1'b1, 3'd0, 64'h0000_0000_8000_0035);
        chk("R3 narrow custom m", m_sel, 64'h0000_0000_8000_0035);
        set_xlen(1'b1);
        chk("R4 moves up s", s_sel, 64'h8000_0000_0000_0035);

        // R5/R10/R11 priority entry 0x33 data path
        access(1'b1, 3'd0, 64'h33);
        access(1'b1, 3'd1, 64'hA5A5_0000_1234_5678);
        chk("R10 alias pre-write", m_rd_c, 64'h0);
        access(1'b0, 3'd1, 64'h0);
        chk("R5 readback m", m_rd_c, 64'hA5A5_0000_1234_5678);
        chk("R5 readback s", s_rd_c, 64'hA5A5_0000_1234_5678);
        set_xlen(1'b0);
        access(1'b1, 3'd1, 64'hFFFF_FFFF_CAFE_F00D);
        chk("R11 narrow read", m_rd_c, 64'h0000_0000_1234_5678);
        set_xlen(1'b1);
        access(1'b0, 3'd1, 64'h0);
        chk("R11 low half write", m_rd_c, 64'hA5A5_0000_CAFE_F00D);

        // R7/R9 secondary and unused targets trap and change nothing
        for (int t = 2; t < 8; t++) begin
            access(1'b1, 3'(t), 64'h1);
            chk("R7 trap m", 64'(m_ill_c), 64'h1);
            chk("R7 trap s", 64'(s_ill_c), 64'h1);
            chk("R9 trap data", m_rd_c, 64'h0);
        end
        access(1'b0, 3'd1, 64'h0);
        chk("R9 unchanged", m_rd_c, 64'hA5A5_0000_CAFE_F00D);

        // R6 interrupt-file stubs
        access(1'b1, 3'd0, 64'h71);
        access(1'b1, 3'd1, 64'hDEAD);
        chk("R6 no file trap", 64'(s_ill_c), 64'h1);
        access(1'b0, 3'd1, 64'h0);
        chk("R6 stub store", m_rd_c, 64'hDEAD);
        chk("R6 no file data", s_rd_c, 64'h0);
        access(1'b1, 3'd0, 64'h90);
        access(1'b1, 3'd1, 64'h55);
        access(1'b0, 3'd1, 64'h0);
        chk("R6 beyond stubs legal", 64'(m_ill_c), 64'h0);
        chk("R6 beyond stubs zero", m_rd_c, 64'h0);

        // R8 reserved index beyond the interrupt-file range
        access(1'b1, 3'd0, 64'h150);
        access(1'b0, 3'd1, 64'h0);
        chk("R8 reserved m", 64'(m_ill_c), 64'h1);
        chk("R8 reserved s", 64'(s_ill_c), 64'h1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule